// File: doc/BRIEF.md
# Indirect Register Window Bridge

This bridge sits between a host access port and a large internal register bus of 512K bytes. The host issues one access at a time. A mode input picks between two ways of reaching the internal space.

In direct mode the host offset is treated as a register number. A fixed register base is added to it, and the sum goes to the internal bus. In window mode only the lowest 256 host bytes decode, and two registers live in that window. An address register holds a register number that the host writes. A data register turns each host read or write into an internal access at that number plus the same base. The latched number stays as it is until the host writes the address register again.

A third access kind reads single bytes from an EEPROM shadow area. The shadow area is organised as 32-bit words. A byte read fetches the aligned word and returns the addressed byte lane.

The internal bus uses a request/ready handshake. While an internal access is outstanding, the host sees a wait-state output. Each access ends with a one-cycle acknowledge. Any access that decodes to nothing reads as all ones, and a write to such an address leaves the internal bus idle.

Top module: `regwin_bridge`

## Requirements
- R1: After reset, host_wait, host_ack and int_req are all low.
- R2: In direct mode (win_mode=0, host_ee=0), an access at host offset h performs an internal access at byte address h + REG_BASE. A read returns the internal word unchanged, and a write carries host_wdata.
- R3: In direct mode, when h + REG_BASE is 2^INT_AW or more, the access is acknowledged without any internal request, and a read returns 32'hFFFFFFFF.
- R4: In window mode (win_mode=1, host_ee=0), a write at window offset ADDR_OFF (default 0x10; bits [1:0] ignored) latches host_wdata as the register number, and a read of that offset returns the latched value.
- R5: In window mode, an access at window offset DATA_OFF (default 0x14) performs an internal read or write at the latched number + REG_BASE.
- R6: The latched number changes only on an address-register write. Data-register accesses, accesses in the other mode and EEPROM reads leave it unchanged.
- R7: In window mode, host offsets of WIN_BYTES (256) or more, and window offsets that are neither register, read as all ones. Writes to them are ignored, and none of them issues an internal request.
- R8: In window mode, when the latched number + REG_BASE is 2^INT_AW or more, a data-register access issues no internal request and a read returns all ones.
- R9: With host_ee=1 and host offset o < EE_BYTES, a read fetches the internal word at EE_BASE + (o & ~3) in either mode. It returns byte lane o[1:0], meaning bits [8*o[1:0] +: 8] of that word, in host_rdata[7:0], with bits [31:8] zero.
- R10: With host_ee=1, a read at o >= EE_BYTES returns all ones, and every write is ignored. Neither issues an internal request.
- R11: int_req holds int_addr, int_wr and int_wdata stable until int_ready. host_wait is high from the cycle after acceptance while the request is pending. host_ack pulses in the cycle after the ready handshake, and int_req is then low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| win_mode | input | 1 | 1 selects window mode, 0 selects direct mode |
| host_req | input | 1 | One-cycle access strobe, taken while host_wait is low |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_ee | input | 1 | 1 = EEPROM shadow byte read |
| host_addr | input | HOST_AW | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_wait | output | 1 | Wait state while an internal access is outstanding |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read data, valid with host_ack on reads |
| int_req | output | 1 | Internal bus request |
| int_wr | output | 1 | Internal bus write |
| int_addr | output | INT_AW | Internal byte address |
| int_wdata | output | 32 | Internal write data |
| int_rdata | input | 32 | Internal read data, taken with int_ready |
| int_ready | input | 1 | Internal bus completion |

## Verification
The bench builds the block with its default parameters: a 20-bit host offset, a 19-bit internal space, a register base of 0x50000 and an EEPROM shadow of 256 bytes at 0x01000. With these values, direct offsets reach the top of the internal space at 0x30000. That makes the overflow edge and the window/data-register translation reachable in a short sweep, and every one of the 256 EEPROM byte offsets can be read exhaustively. A bench memory model with a ready latency of 0 to 3 cycles covers both immediate and delayed handshakes.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  typedef enum logic [1:0] {
    ACT_LOCAL = 2'd0,
    ACT_BUS_RD = 2'd1,
    ACT_BUS_WR = 2'd2
  } rw_act_e;

  // 33-bit sum so that an overflow past the internal space stays visible
  function automatic logic [32:0] rw_add(input logic [31:0] a, input logic [31:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic rw_fits(input logic [32:0] s, input int aw);
    return (s >> aw) == 33'd0;
  endfunction

  function automatic logic [31:0] rw_align(input logic [31:0] a);
    return {a[31:2], 2'b00};
  endfunction

  function automatic logic [7:0] rw_lane(input logic [31:0] w, input logic [1:0] l);
    return w[8*l +: 8];
  endfunction

endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
  import regwin_pkg::*;
#(
  parameter int HOST_AW = 20,
  parameter int INT_AW = 19,
  parameter int WIN_BYTES = 256,
  parameter int ADDR_OFF = 'h10,
  parameter int DATA_OFF = 'h14,
  parameter logic [31:0] REG_BASE = 32'h0005_0000,
  parameter logic [31:0] EE_BASE = 32'h0000_1000,
  parameter int EE_BYTES = 256
) (
  input logic win_mode,
  input logic host_wr,
  input logic host_ee,
  input logic [HOST_AW-1:0] host_addr,
  input logic [31:0] latch_q,
  output rw_act_e act,
  output logic [INT_AW-1:0] bus_addr,
  output logic [31:0] local_rdata,
  output logic latch_we,
  output logic ee_sel,
  output logic [1:0] ee_lane
);
  localparam int WIN_AW = $clog2(WIN_BYTES);
  localparam logic [31:0] WIN_LIM = 32'(WIN_BYTES);
  localparam logic [31:0] EE_LIM = 32'(EE_BYTES);
  localparam logic [WIN_AW-1:0] ADDR_W = WIN_AW'(ADDR_OFF);
  localparam logic [WIN_AW-1:0] DATA_W = WIN_AW'(DATA_OFF);

  logic [31:0] haddr;
  logic [32:0] sum;
  logic [WIN_AW-1:0] off;

  assign haddr = {{(32-HOST_AW){1'b0}}, host_addr};
  assign off = host_addr[WIN_AW-1:0];

  always_comb begin
    act = ACT_LOCAL;
    bus_addr = '0;
    local_rdata = '1;
    latch_we = 1'b0;
    ee_sel = 1'b0;
    ee_lane = host_addr[1:0];
    sum = '0;
    if (host_ee) begin
      sum = rw_add(rw_align(haddr), EE_BASE);
      if (!host_wr && haddr < EE_LIM && rw_fits(sum, INT_AW)) begin
        act = ACT_BUS_RD;
        bus_addr = sum[INT_AW-1:0];
        ee_sel = 1'b1;
      end
    end else if (win_mode) begin
      sum = rw_add(latch_q, REG_BASE);
      if (haddr < WIN_LIM) begin
        if (off[WIN_AW-1:2] == ADDR_W[WIN_AW-1:2]) begin
          latch_we = host_wr;
          local_rdata = latch_q;
        end else if (off[WIN_AW-1:2] == DATA_W[WIN_AW-1:2] && rw_fits(sum, INT_AW)) begin
          act = host_wr ? ACT_BUS_WR : ACT_BUS_RD;
          bus_addr = sum[INT_AW-1:0];
        end
      end
    end else begin
      sum = rw_add(haddr, REG_BASE);
      if (rw_fits(sum, INT_AW)) begin
        act = host_wr ? ACT_BUS_WR : ACT_BUS_RD;
        bus_addr = sum[INT_AW-1:0];
      end
    end
  end
endmodule

// File: rtl/regwin_latch.sv
module regwin_latch (
  input logic clk,
  input logic rst_n,
  input logic load,
  input logic [31:0] din,
  output logic [31:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/regwin_seq.sv
module regwin_seq
  import regwin_pkg::*;
#(
  parameter int INT_AW = 19
) (
  input logic clk,
  input logic rst_n,
  input logic accept,
  input logic host_wr,
  input logic [31:0] host_wdata,
  input rw_act_e act,
  input logic [INT_AW-1:0] bus_addr,
  input logic [31:0] local_rdata,
  input logic ee_sel,
  input logic [1:0] ee_lane,
  output logic busy,
  output logic host_ack,
  output logic [31:0] host_rdata,
  output logic int_wr,
  output logic [INT_AW-1:0] int_addr,
  output logic [31:0] int_wdata,
  input logic [31:0] int_rdata,
  input logic int_ready
);
  logic ee_q;
  logic [1:0] lane_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      host_ack <= 1'b0;
      host_rdata <= '0;
      int_wr <= 1'b0;
      int_addr <= '0;
      int_wdata <= '0;
      ee_q <= 1'b0;
      lane_q <= '0;
    end else begin
      host_ack <= 1'b0;
      if (busy) begin
        if (int_ready) begin
          busy <= 1'b0;
          host_ack <= 1'b1;
          if (!int_wr)
            host_rdata <= ee_q ? {24'd0, rw_lane(int_rdata, lane_q)} : int_rdata;
        end
      end else if (accept) begin
        if (act == ACT_LOCAL) begin
          host_ack <= 1'b1;
          if (!host_wr) host_rdata <= local_rdata;
        end else begin
          busy <= 1'b1;
          int_wr <= (act == ACT_BUS_WR);
          int_addr <= bus_addr;
          int_wdata <= host_wdata;
          ee_q <= ee_sel;
          lane_q <= ee_lane;
        end
      end
    end
  end
endmodule

// File: rtl/regwin_bridge.sv
module regwin_bridge
  import regwin_pkg::*;
#(
  parameter int HOST_AW = 20,
  parameter int INT_AW = 19,
  parameter int WIN_BYTES = 256,
  parameter int ADDR_OFF = 'h10,
  parameter int DATA_OFF = 'h14,
  parameter logic [31:0] REG_BASE = 32'h0005_0000,
  parameter logic [31:0] EE_BASE = 32'h0000_1000,
  parameter int EE_BYTES = 256
) (
  input logic clk,
  input logic rst_n,
  input logic win_mode,
  input logic host_req,
  input logic host_wr,
  input logic host_ee,
  input logic [HOST_AW-1:0] host_addr,
  input logic [31:0] host_wdata,
  output logic host_wait,
  output logic host_ack,
  output logic [31:0] host_rdata,
  output logic int_req,
  output logic int_wr,
  output logic [INT_AW-1:0] int_addr,
  output logic [31:0] int_wdata,
  input logic [31:0] int_rdata,
  input logic int_ready
);
  rw_act_e act;
  logic [INT_AW-1:0] bus_addr;
  logic [31:0] local_rdata;
  logic [31:0] latch_q;
  logic latch_we, latch_load, ee_sel, busy, accept;
  logic [1:0] ee_lane;

  assign accept = host_req && !busy;
  assign latch_load = accept && latch_we;
  assign host_wait = busy;
  assign int_req = busy;

  regwin_decode #(
    .HOST_AW(HOST_AW), .INT_AW(INT_AW), .WIN_BYTES(WIN_BYTES),
    .ADDR_OFF(ADDR_OFF), .DATA_OFF(DATA_OFF), .REG_BASE(REG_BASE),
    .EE_BASE(EE_BASE), .EE_BYTES(EE_BYTES)
  ) u_decode (
    .win_mode(win_mode), .host_wr(host_wr), .host_ee(host_ee),
    .host_addr(host_addr), .latch_q(latch_q), .act(act),
    .bus_addr(bus_addr), .local_rdata(local_rdata), .latch_we(latch_we),
    .ee_sel(ee_sel), .ee_lane(ee_lane)
  );

  regwin_latch u_latch (
    .clk(clk), .rst_n(rst_n), .load(latch_load), .din(host_wdata), .q(latch_q)
  );

  regwin_seq #(.INT_AW(INT_AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .host_wr(host_wr),
    .host_wdata(host_wdata), .act(act), .bus_addr(bus_addr),
    .local_rdata(local_rdata), .ee_sel(ee_sel), .ee_lane(ee_lane),
    .busy(busy), .host_ack(host_ack), .host_rdata(host_rdata),
    .int_wr(int_wr), .int_addr(int_addr), .int_wdata(int_wdata),
    .int_rdata(int_rdata), .int_ready(int_ready)
  );
endmodule

// File: rtl/regwin_bridge_chk.sv
module regwin_bridge_chk #(
  parameter int HOST_AW = 20,
  parameter int INT_AW = 19,
  parameter int WIN_BYTES = 256,
  parameter logic [31:0] REG_BASE = 32'h0005_0000,
  parameter logic [31:0] EE_BASE = 32'h0000_1000,
  parameter int EE_BYTES = 256
) (
  input logic clk,
  input logic rst_n,
  input logic win_mode,
  input logic host_req,
  input logic host_wr,
  input logic host_ee,
  input logic [HOST_AW-1:0] host_addr,
  input logic host_wait,
  input logic host_ack,
  input logic [31:0] host_rdata,
  input logic int_req,
  input logic int_wr,
  input logic [INT_AW-1:0] int_addr,
  input logic [31:0] int_wdata,
  input logic int_ready,
  input logic latch_load,
  input logic [31:0] latch_q
);
  logic acc;
  logic [32:0] haddr33, dsum, esum;
  assign acc = host_req && !host_wait;
  assign haddr33 = {{(33-HOST_AW){1'b0}}, host_addr};
  assign dsum = haddr33 + {1'b0, REG_BASE};
  assign esum = {haddr33[32:2], 2'b00} + {1'b0, EE_BASE};

  assert_direct_over_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !win_mode && !host_ee && (dsum >> INT_AW) != 0 |=> host_ack && !int_req);

  assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_load |=> $stable(latch_q));

  assert_win_outside_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && win_mode && !host_ee && haddr33 >= 33'(WIN_BYTES) |=> host_ack && !int_req);

  assert_ee_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc && host_ee && !host_wr && haddr33 < 33'(EE_BYTES)
    |=> int_req && !int_wr && int_addr == $past(esum[INT_AW-1:0]));

  assert_ee_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc && host_ee && host_wr |=> host_ack && !int_req);

  assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    int_req && !int_ready |=> int_req && $stable(int_addr) && $stable(int_wr) && $stable(int_wdata));

  assert_ack_after_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    int_req && int_ready |=> host_ack && !int_req && !host_wait);
endmodule

bind regwin_bridge regwin_bridge_chk #(
  .HOST_AW(HOST_AW), .INT_AW(INT_AW), .WIN_BYTES(WIN_BYTES),
  .REG_BASE(REG_BASE), .EE_BASE(EE_BASE), .EE_BYTES(EE_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .win_mode(win_mode), .host_req(host_req),
  .host_wr(host_wr), .host_ee(host_ee), .host_addr(host_addr),
  .host_wait(host_wait), .host_ack(host_ack), .host_rdata(host_rdata),
  .int_req(int_req), .int_wr(int_wr), .int_addr(int_addr),
  .int_wdata(int_wdata), .int_ready(int_ready),
  .latch_load(latch_load), .latch_q(latch_q)
);

// File: tb/regwin_bridge_bench.sv
module regwin_bridge_bench;
  localparam logic [31:0] RBASE = 32'h0005_0000;
  localparam logic [31:0] EBASE = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic win_mode = 1'b0, host_req = 1'b0, host_wr = 1'b0, host_ee = 1'b0;
  logic [19:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic host_wait, host_ack, int_req, int_wr;
  logic [31:0] host_rdata, int_wdata;
  logic [18:0] int_addr;
  logic [31:0] int_rdata = '0;
  logic int_ready = 1'b0;

  int checks = 0, errors = 0, bus_n = 0, lat = 0, cnt = 0;
  logic [18:0] last_addr = '0;
  logic [31:0] wmem [logic [18:0]];

  always #4 clk = ~clk;

  regwin_bridge u_regwin_bridge (
    .clk(clk), .rst_n(rst_n), .win_mode(win_mode), .host_req(host_req),
    .host_wr(host_wr), .host_ee(host_ee), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_wait(host_wait), .host_ack(host_ack),
    .host_rdata(host_rdata), .int_req(int_req), .int_wr(int_wr),
    .int_addr(int_addr), .int_wdata(int_wdata), .int_rdata(int_rdata),
    .int_ready(int_ready)
  );

  function automatic logic [31:0] mem_rd(input logic [18:0] a);
    if (wmem.exists(a)) return wmem[a];
    return (32'(a) * 32'h0001_0003) ^ 32'h5A5A_0F0F;
  endfunction

  // internal bus model: ready after lat+1 cycles of request
  always @(posedge clk) begin
    if (!rst_n) begin
      int_ready <= 1'b0;
      cnt <= 0;
    end else if (int_req) begin
      if (int_ready) begin
        int_ready <= 1'b0;
        cnt <= 0;
        bus_n = bus_n + 1;
        last_addr = int_addr;
        if (int_wr) wmem[int_addr] = int_wdata;
      end else if (cnt >= lat) begin
        int_ready <= 1'b1;
        int_rdata <= mem_rd(int_addr);
      end else cnt <= cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic ee, input logic wr, input logic [19:0] a,
                        input logic [31:0] d, output logic [31:0] r, output logic w0);
    @(negedge clk);
    host_req = 1'b1; host_ee = ee; host_wr = wr; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_req = 1'b0;
    w0 = host_wait;
    while (!host_ack) @(negedge clk);
    r = host_rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r, e;
    logic w0;
    int b0;
    repeat (3) @(negedge clk);
    chk("R1 wait", {31'd0, host_wait}, 0);
    chk("R1 ack", {31'd0, host_ack}, 0);
    chk("R1 req", {31'd0, int_req}, 0);
    rst_n = 1'b1;

    // R2 / R3 direct sweep
    win_mode = 1'b0;
    for (int i = 0; i < 48; i++) begin
      logic [19:0] h = 20'(i * 32'h1000 + (i % 4) * 4);
      lat = i % 4;
      access(0, 0, h, 0, r, w0);
      chk("R2 direct read", r, mem_rd(19'(32'(h) + RBASE)));
    end
    access(0, 1, 20'h0_0124, 32'hCAFE_0001, r, w0);
    chk("R2 direct write addr", 32'(last_addr), 32'h0005_0124);
    access(0, 0, 20'h0_0124, 0, r, w0);
    chk("R2 direct readback", r, 32'hCAFE_0001);
    access(0, 0, 20'h2_FFFC, 0, r, w0);
    chk("R2 top of space", r, mem_rd(19'h7FFFC));
    b0 = bus_n;
    access(0, 0, 20'h3_0000, 0, r, w0);
    chk("R3 over read", r, 32'hFFFF_FFFF);
    access(0, 1, 20'hF_FFFC, 32'h1234, r, w0);
    access(0, 0, 20'h8_0000, 0, r, w0);
    chk("R3 over read far", r, 32'hFFFF_FFFF);
    chk("R3 no bus", 32'(bus_n), 32'(b0));

    // R4 / R5 / R6 window
    win_mode = 1'b1;
    for (int i = 0; i < 16; i++) begin
      logic [31:0] n = 32'(i * 32'h1104 + 8);
      lat = (i + 1) % 4;
      access(0, 1, 20'h10, n, r, w0);
      access(0, 0, 20'h10, 0, r, w0);
      chk("R4 addr readback", r, n);
      access(0, 0, 20'h14, 0, r, w0);
      chk("R5 data read", r, mem_rd(19'(n + RBASE)));
      access(0, 1, 20'h17, 32'hBEEF_0000 + 32'(i), r, w0);
      chk("R5 data write addr", 32'(last_addr), n + RBASE);
      access(0, 0, 20'h14, 0, r, w0);
      chk("R5 data readback", r, 32'hBEEF_0000 + 32'(i));
      access(0, 0, 20'h11, 0, r, w0);
      chk("R6 latch after data", r, n);
    end
    access(0, 1, 20'h10, 32'h0000_0700, r, w0);
    win_mode = 1'b0;
    access(0, 1, 20'h0_0010, 32'h5555, r, w0);
    access(1, 0, 20'h0_0003, 0, r, w0);
    win_mode = 1'b1;
    access(0, 0, 20'h10, 0, r, w0);
    chk("R6 latch after other", r, 32'h0000_0700);

    // R7 outside / unassigned
    b0 = bus_n;
    access(0, 0, 20'h100, 0, r, w0);
    chk("R7 outside read", r, 32'hFFFF_FFFF);
    access(0, 0, 20'h1F0, 0, r, w0);
    chk("R7 far read", r, 32'hFFFF_FFFF);
    access(0, 1, 20'h110, 32'h9999, r, w0);
    access(0, 0, 20'h08, 0, r, w0);
    chk("R7 unused offset", r, 32'hFFFF_FFFF);
    access(0, 1, 20'h18, 32'h7777, r, w0);
    access(0, 0, 20'h10, 0, r, w0);
    chk("R7 latch untouched", r, 32'h0000_0700);
    chk("R7 no bus", 32'(bus_n), 32'(b0));

    // R8 latch beyond space
    access(0, 1, 20'h10, 32'h0003_0000, r, w0);
    access(0, 0, 20'h14, 0, r, w0);
    chk("R8 over read", r, 32'hFFFF_FFFF);
    access(0, 1, 20'h14, 32'h1, r, w0);
    chk("R8 no bus", 32'(bus_n), 32'(b0));
    access(0, 1, 20'h10, 32'h0002_FFFC, r, w0);
    access(0, 0, 20'h14, 0, r, w0);
    chk("R8 top edge", r, mem_rd(19'h7FFFC));

    // R9 / R10 EEPROM bytes, exhaustive
    for (int o = 0; o < 256; o++) begin
      win_mode = o[0];
      lat = o % 3;
      access(1, 0, 20'(o), 0, r, w0);
      e = mem_rd(19'(EBASE + 32'(o & ~3)));
      chk("R9 ee byte", r, {24'd0, e[8*(o%4) +: 8]});
    end
    b0 = bus_n;
    access(1, 0, 20'd256, 0, r, w0);
    chk("R10 ee over", r, 32'hFFFF_FFFF);
    access(1, 1, 20'd4, 32'h1111, r, w0);
    chk("R10 ee write no bus", 32'(bus_n), 32'(b0));
    access(1, 0, 20'd4, 0, r, w0);
    e = mem_rd(19'(EBASE + 4));
    chk("R10 ee unchanged", r, {24'd0, e[7:0]});

    // R11 wait state
    win_mode = 1'b0;
    lat = 3;
    access(0, 0, 20'h40, 0, r, w0);
    chk("R11 wait during read", {31'd0, w0}, 1);
    chk("R11 wait clear at ack", {31'd0, host_wait}, 0);
    @(negedge clk);
    chk("R11 ack single", {31'd0, host_ack}, 0);
    chk("R11 req idle", {31'd0, int_req}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule